// File: doc/BRIEF.md
# Match Timer with Watchdog Channel

This block is a memory-mapped timer. It holds a free-running 64-bit up-counter that advances by one on each tick-enable pulse, and six 32-bit match channels. Each channel compares its match value with the low 32 bits of the counter. A channel sets its sticky status bit in the cycle the counter moves onto the matching value. The channel's interrupt output is asserted while its status bit and its interrupt enable bit are both set.

The last channel can also act as a watchdog. Software arms a timeout in three steps. It writes the latch command to snapshot the counter. It reads the snapshot. It then writes snapshot plus a tick count, modulo 2^32, into the watchdog channel. When watchdog mode is on and the watchdog channel's interrupt enable is set, a match on that channel produces a single-cycle system reset request. Software reaches all registers through a simple register port: writes take effect at the clock edge, and read data depends combinationally on the address.

Top module: `tick_match_wdog`

## Requirements
- R1: After reset, every register reads zero, `irq` is zero and `wdogRstReq` is low.
- R2: The 64-bit counter increases by exactly one at each clock edge where `tickEn` is high, holds otherwise, and reads as low word at 0x00 and high word at 0x04.
- R3: Match channel n (n = 0..5) is a read/write 32-bit register at byte offset 0x08 + 4*n.
- R4: Status bit n, at offset 0x2C bits 5:0, becomes set at the clock edge where a tick moves the counter onto a value whose low word equals match n. It stays set, and it is never set without a tick.
- R5: Writing offset 0x2C clears each status bit whose data bit is 1. A match at the same edge sets that bit anyway, so the set wins over the clear.
- R6: `irq[n]` is high exactly when status bit n and interrupt enable bit n (offset 0x24, bits 5:0) are both set.
- R7: When a tick moves the counter onto match 5 while watchdog enable (offset 0x28 bit 0) and interrupt enable bit 5 are both set, `wdogRstReq` is high for exactly the one following cycle.
- R8: No reset request occurs if watchdog enable or interrupt enable bit 5 is clear before that edge. Status bit 5 is still set.
- R9: Writing a value with bit 0 = 1 to offset 0x30 copies the counter value held before that edge into the snapshot, read at 0x34 (low) and 0x38 (high). The snapshot then stays stable. Writing 0 to 0x30 copies nothing, and 0x30 reads zero.
- R10: Writes to the counter words (0x00, 0x04) and snapshot words (0x34, 0x38) are ignored. Undefined offsets (such as 0x20, 0x3C and unaligned addresses) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance pulse |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe, takes effect at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| irq | output | 6 | Per-channel interrupt (status AND enable) |
| wdogRstReq | output | 1 | One-cycle system reset request from the watchdog channel |

## Verification
Directed sequences arm single channels a few ticks ahead of the counter. They tell an exact-edge equality compare from an off-by-one compare. They also separate the four combinations of watchdog enable and interrupt enable bit 5, which shows whether the reset request is gated by both bits or by only one. A clear write that lands on a matching tick distinguishes set-wins from clear-wins. Snapshot writes with data 1 and data 0 test capture timing and the command's data dependence. Random traffic with ticks, match values placed close to the counter, enable changes, clears and reads exposes how the channels interact when several match together.

// File: rtl/tmw_pkg.sv
package tmw_pkg;
  localparam int CH_IDX_W = 3;

  localparam logic [7:0] OFF_CNT_LO  = 8'h00;
  localparam logic [7:0] OFF_CNT_HI  = 8'h04;
  localparam logic [7:0] OFF_MATCH0  = 8'h08;
  localparam logic [7:0] OFF_INT_EN  = 8'h24;
  localparam logic [7:0] OFF_WD_EN   = 8'h28;
  localparam logic [7:0] OFF_STATUS  = 8'h2C;
  localparam logic [7:0] OFF_LATCH   = 8'h30;
  localparam logic [7:0] OFF_SNAP_LO = 8'h34;
  localparam logic [7:0] OFF_SNAP_HI = 8'h38;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_CNT_LO,
    RD_CNT_HI,
    RD_MATCH,
    RD_INT_EN,
    RD_WD_EN,
    RD_STATUS,
    RD_SNAP_LO,
    RD_SNAP_HI
  } rd_sel_e;

  typedef struct packed {
    logic                wrMatch;
    logic [CH_IDX_W-1:0] chSel;
    logic                wrIntEn;
    logic                wrWdEn;
    logic                clrStatus;
    logic                snapCap;
    rd_sel_e             rdSel;
  } ctl_strobe_t;
endpackage

// File: rtl/tmw_ctrl.sv
module tmw_ctrl
  import tmw_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              wrBit0,
  output ctl_strobe_t       strb
);
  function automatic logic hitOff(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    for (int n = 0; n < NUM_CH; n++) begin
      if (busAddr == ADDR_W'(int'(OFF_MATCH0) + 4 * n)) begin
        strb.wrMatch = busWrEn;
        strb.chSel   = CH_IDX_W'(n);
        strb.rdSel   = RD_MATCH;
      end
    end
    if (hitOff(busAddr, OFF_CNT_LO))  strb.rdSel = RD_CNT_LO;
    if (hitOff(busAddr, OFF_CNT_HI))  strb.rdSel = RD_CNT_HI;
    if (hitOff(busAddr, OFF_SNAP_LO)) strb.rdSel = RD_SNAP_LO;
    if (hitOff(busAddr, OFF_SNAP_HI)) strb.rdSel = RD_SNAP_HI;
    if (hitOff(busAddr, OFF_INT_EN)) begin
      strb.rdSel   = RD_INT_EN;
      strb.wrIntEn = busWrEn;
    end
    if (hitOff(busAddr, OFF_WD_EN)) begin
      strb.rdSel  = RD_WD_EN;
      strb.wrWdEn = busWrEn;
    end
    if (hitOff(busAddr, OFF_STATUS)) begin
      strb.rdSel     = RD_STATUS;
      strb.clrStatus = busWrEn;
    end
    if (hitOff(busAddr, OFF_LATCH)) begin
      strb.snapCap = busWrEn & wrBit0;
    end
  end
endmodule

// File: rtl/tmw_datapath.sv
module tmw_datapath
  import tmw_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int WORD_W  = 32,
  parameter int WDOG_CH = NUM_CH - 1,
  localparam int CNT_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [WORD_W-1:0] wrData,
  input  ctl_strobe_t       strb,
  output logic [WORD_W-1:0] rdData,
  output logic [NUM_CH-1:0] irq,
  output logic              wdogRstReq,
  output logic [CNT_W-1:0]  cntVal,
  output logic [NUM_CH-1:0] intEnReg,
  output logic              wdEnReg,
  output logic [NUM_CH-1:0] statusReg
);
  logic [CNT_W-1:0]                cntNext;
  logic [CNT_W-1:0]                snapReg;
  logic [NUM_CH-1:0][WORD_W-1:0]   matchArr;
  logic [NUM_CH-1:0]               hitVec;
  logic [NUM_CH-1:0]               clrMask;

  assign cntNext = cntVal + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)       cntVal <= '0;
    else if (tickEn) cntVal <= cntNext;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [WORD_W-1:0] matchQ;
    always_ff @(posedge clk) begin
      if (!rstN) matchQ <= '0;
      else if (strb.wrMatch && strb.chSel == CH_IDX_W'(ch)) matchQ <= wrData;
    end
    assign matchArr[ch] = matchQ;
    assign hitVec[ch]   = tickEn && (cntNext[WORD_W-1:0] == matchQ);
  end

  assign clrMask = strb.clrStatus ? wrData[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEnReg   <= '0;
      wdEnReg    <= 1'b0;
      statusReg  <= '0;
      snapReg    <= '0;
      wdogRstReq <= 1'b0;
    end else begin
      if (strb.wrIntEn) intEnReg <= wrData[NUM_CH-1:0];
      if (strb.wrWdEn)  wdEnReg  <= wrData[0];
      statusReg  <= (statusReg & ~clrMask) | hitVec;
      if (strb.snapCap) snapReg <= cntVal;
      wdogRstReq <= hitVec[WDOG_CH] & wdEnReg & intEnReg[WDOG_CH];
    end
  end

  assign irq = statusReg & intEnReg;

  always_comb begin
    unique case (strb.rdSel)
      RD_CNT_LO:  rdData = cntVal[WORD_W-1:0];
      RD_CNT_HI:  rdData = cntVal[CNT_W-1:WORD_W];
      RD_MATCH:   rdData = matchArr[strb.chSel];
      RD_INT_EN:  rdData = WORD_W'(intEnReg);
      RD_WD_EN:   rdData = WORD_W'(wdEnReg);
      RD_STATUS:  rdData = WORD_W'(statusReg);
      RD_SNAP_LO: rdData = snapReg[WORD_W-1:0];
      RD_SNAP_HI: rdData = snapReg[CNT_W-1:WORD_W];
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/tick_match_wdog.sv
module tick_match_wdog
  import tmw_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 8,
  localparam int WDOG_CH = NUM_CH - 1,
  localparam int CNT_W   = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  output logic [NUM_CH-1:0] irq,
  output logic              wdogRstReq
);
  ctl_strobe_t       strb;
  logic [CNT_W-1:0]  cntVal;
  logic [NUM_CH-1:0] intEnReg;
  logic              wdEnReg;
  logic [NUM_CH-1:0] statusReg;

  tmw_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .wrBit0 (busWrData[0]),
    .strb   (strb)
  );

  tmw_datapath #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .WDOG_CH(WDOG_CH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .wrData    (busWrData),
    .strb      (strb),
    .rdData    (busRdData),
    .irq       (irq),
    .wdogRstReq(wdogRstReq),
    .cntVal    (cntVal),
    .intEnReg  (intEnReg),
    .wdEnReg   (wdEnReg),
    .statusReg (statusReg)
  );
endmodule

// File: rtl/tmw_checker.sv
module tmw_checker #(
  parameter int NUM_CH  = 6,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int WDOG_CH = NUM_CH - 1,
  localparam int CNT_W  = 2 * WORD_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [NUM_CH-1:0] irq,
  input logic              wdogRstReq,
  input logic [CNT_W-1:0]  cntVal,
  input logic [NUM_CH-1:0] intEnReg,
  input logic              wdEnReg,
  input logic [NUM_CH-1:0] statusReg
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(8'h2C);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> cntVal == $past(cntVal) + CNT_W'(1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> cntVal == $past(cntVal));

  // R4: a status bit is only raised by a tick
  p_status_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> (statusReg & ~$past(statusReg)) == '0);

  // R5: bits only fall on a write to the status offset
  p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == STAT_ADDR) |=> (statusReg & $past(statusReg)) == $past(statusReg));

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~intEnReg) == '0);

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    wdogRstReq |=> !wdogRstReq);

  p_pulse_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    wdogRstReq |-> $past(wdEnReg && intEnReg[WDOG_CH] && tickEn));
endmodule

bind tick_match_wdog tmw_checker #(
  .NUM_CH(NUM_CH), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .WDOG_CH(WDOG_CH)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .irq       (irq),
  .wdogRstReq(wdogRstReq),
  .cntVal    (cntVal),
  .intEnReg  (intEnReg),
  .wdEnReg   (wdEnReg),
  .statusReg (statusReg)
);

// File: tb/tick_match_wdog_tb.sv
module tick_match_wdog_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [5:0]  irq;
  logic        wdogRstReq;

  int checks = 0;
  int errors = 0;

  // bench reference state
  logic [63:0] mCnt;
  logic [31:0] mMatch [6];
  logic [5:0]  mIntEn;
  logic        mWdEn;
  logic [5:0]  mStat;
  logic [63:0] mSnap;
  logic        mRst;

  tick_match_wdog u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irq(irq), .wdogRstReq(wdogRstReq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    if (a >= 8'h08 && a <= 8'h1C && a[1:0] == 2'b00) return mMatch[(a - 8'h08) >> 2];
    case (a)
      8'h00: return mCnt[31:0];
      8'h04: return mCnt[63:32];
      8'h24: return {26'd0, mIntEn};
      8'h28: return {31'd0, mWdEn};
      8'h2C: return {26'd0, mStat};
      8'h34: return mSnap[31:0];
      8'h38: return mSnap[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqOf(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h04) return "R2";
    if (a >= 8'h08 && a <= 8'h1C) return "R3";
    if (a == 8'h2C) return "R4";
    if (a == 8'h34 || a == 8'h38) return "R9";
    if (a == 8'h24 || a == 8'h28) return "R6";
    return "R10";
  endfunction

  task automatic modelReset();
    mCnt = '0; mIntEn = '0; mWdEn = 1'b0; mStat = '0; mSnap = '0; mRst = 1'b0;
    for (int i = 0; i < 6; i++) mMatch[i] = '0;
  endtask

  // one clock with the given inputs; outputs checked at the next falling edge
  task automatic cyc(input logic tk, input logic we, input logic [7:0] a, input logic [31:0] d);
    logic [63:0] nxt;
    logic [5:0]  hit;
    tickEn = tk; busWrEn = we; busAddr = a; busWrData = d;
    nxt = tk ? mCnt + 64'd1 : mCnt;
    for (int i = 0; i < 6; i++) hit[i] = tk && (nxt[31:0] == mMatch[i]);
    mRst = hit[5] && mWdEn && mIntEn[5];
    if (we && a == 8'h2C) mStat = mStat & ~d[5:0];
    mStat = mStat | hit;
    if (we && a == 8'h30 && d[0]) mSnap = mCnt;
    if (we && a >= 8'h08 && a <= 8'h1C && a[1:0] == 2'b00) mMatch[(a - 8'h08) >> 2] = d;
    if (we && a == 8'h24) mIntEn = d[5:0];
    if (we && a == 8'h28) mWdEn = d[0];
    mCnt = nxt;
    @(posedge clk);
    @(negedge clk);
    tickEn = 1'b0; busWrEn = 1'b0;
    check("R6 irq", {58'd0, irq}, {58'd0, mStat & mIntEn});
    check("R7/R8 wdogRstReq", {63'd0, wdogRstReq}, {63'd0, mRst});
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    busWrEn = 1'b0; tickEn = 1'b0; busAddr = a;
    #1;
    check(req, {32'd0, busRdData}, {32'd0, modelRead(a)});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 32'd0);
  endtask

  task automatic mainSeq();
    logic [7:0] offs [13];
    int pulses;
    offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
             8'h24, 8'h28, 8'h2C, 8'h34, 8'h38};
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int i = 0; i < 13; i++) rd(offs[i], "R1 reset value");
    check("R1 irq after reset", {58'd0, irq}, 64'd0);
    check("R1 wdogRstReq after reset", {63'd0, wdogRstReq}, 64'd0);

    // R2: counting and holding
    ticks(5);
    rd(8'h00, "R2 count after 5 ticks");
    check("R2 count is 5", {32'd0, busRdData}, 64'd5);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 8'h00, 32'd0);
    rd(8'h00, "R2 hold without tick");
    rd(8'h04, "R2 high word");

    // R3: match registers
    for (int n = 0; n < 6; n++) cyc(1'b0, 1'b1, 8'(8'h08 + 4 * n), 32'hA500_0000 | 32'(n * 17));
    for (int n = 0; n < 6; n++) rd(8'(8'h08 + 4 * n), "R3 match readback");

    // R10: read-only and undefined offsets
    cyc(1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b1, 8'h04, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b1, 8'h34, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b1, 8'h38, 32'hFFFF_FFFF);
    rd(8'h00, "R10 counter write ignored");
    rd(8'h04, "R10 counter high write ignored");
    rd(8'h34, "R10 snapshot write ignored");
    rd(8'h38, "R10 snapshot high write ignored");
    rd(8'h20, "R10 undefined 0x20");
    rd(8'h3C, "R10 undefined 0x3C");
    rd(8'h09, "R10 unaligned 0x09");
    rd(8'h30, "R9 latch command reads zero");

    // R4: exact-edge compare on channel 0
    cyc(1'b0, 1'b1, 8'h08, mCnt[31:0] + 32'd3);
    cyc(1'b0, 1'b1, 8'h24, 32'h01);
    ticks(2);
    check("R4 no status before match", {58'd0, irq}, 64'd0);
    ticks(1);
    check("R4 status on matching tick", {58'd0, irq}, 64'd1);
    rd(8'h2C, "R4 status register");
    ticks(3);
    rd(8'h2C, "R4 status sticky");

    // R5: write-1-to-clear and set-wins
    cyc(1'b0, 1'b1, 8'h2C, 32'h01);
    rd(8'h2C, "R5 cleared by write 1");
    cyc(1'b0, 1'b1, 8'h0C, mCnt[31:0] + 32'd1);
    cyc(1'b1, 1'b1, 8'h2C, 32'h02);
    rd(8'h2C, "R5 set wins over clear");
    check("R5 bit1 set", {63'd0, busRdData[1]}, 64'd1);
    cyc(1'b0, 1'b1, 8'h2C, 32'h3F);

    // R7: watchdog fires with both enables
    cyc(1'b0, 1'b1, 8'h24, 32'h20);
    cyc(1'b0, 1'b1, 8'h28, 32'h1);
    cyc(1'b0, 1'b1, 8'h1C, mCnt[31:0] + 32'd4);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, 8'h00, 32'd0);
      if (wdogRstReq) pulses++;
      if (i == 3) check("R7 pulse on 4th tick", {63'd0, wdogRstReq}, 64'd1);
    end
    check("R7 exactly one pulse", 64'(pulses), 64'd1);

    // R8: each enable alone is not enough
    cyc(1'b0, 1'b1, 8'h2C, 32'h3F);
    cyc(1'b0, 1'b1, 8'h24, 32'h00);
    cyc(1'b0, 1'b1, 8'h1C, mCnt[31:0] + 32'd2);
    ticks(2);
    check("R8 no pulse with int enable 5 clear", {63'd0, wdogRstReq}, 64'd0);
    rd(8'h2C, "R8 status still set");
    cyc(1'b0, 1'b1, 8'h24, 32'h20);
    cyc(1'b0, 1'b1, 8'h28, 32'h0);
    cyc(1'b0, 1'b1, 8'h1C, mCnt[31:0] + 32'd2);
    ticks(2);
    check("R8 no pulse with watchdog enable clear", {63'd0, wdogRstReq}, 64'd0);

    // R9: snapshot
    ticks(3);
    cyc(1'b1, 1'b1, 8'h30, 32'h1);
    rd(8'h34, "R9 snapshot low");
    check("R9 snapshot is pre-edge count", {32'd0, busRdData}, {32'd0, mCnt[31:0] - 32'd1});
    ticks(4);
    rd(8'h34, "R9 snapshot stable");
    rd(8'h38, "R9 snapshot high");
    cyc(1'b0, 1'b1, 8'h30, 32'h0);
    rd(8'h34, "R9 write 0 does not capture");

    // random traffic
    for (int it = 0; it < 3000; it++) begin
      logic tk;
      int op;
      tk = ($urandom % 10) < 7;
      op = $urandom % 9;
      case (op)
        0, 1: cyc(tk, 1'b1, 8'(8'h08 + 4 * ($urandom % 6)), mCnt[31:0] + 32'($urandom % 12));
        2:    cyc(tk, 1'b1, 8'h24, $urandom);
        3:    cyc(tk, 1'b1, 8'h28, $urandom);
        4:    cyc(tk, 1'b1, 8'h2C, $urandom);
        5:    cyc(tk, 1'b1, 8'h30, $urandom);
        6: begin
          logic [7:0] a;
          a = 8'($urandom % 64);
          rd(a, reqOf(a));
        end
        default: cyc(tk, 1'b0, 8'h00, 32'd0);
      endcase
    end
    for (int i = 0; i < 13; i++) rd(offs[i], reqOf(offs[i]));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      mainSeq();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual=hung expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule